// File: doc/BRIEF.md
# Board control register file with character display

This block is the memory-mapped control point of a development board. A processor reaches it over a plain 32-bit register bus (address, write strobe, read strobe, write data, read data), and only the low 20 address bits take part in decoding. Because of this, the whole register set appears again at every 1 MiB boundary. The block holds an LED bar byte, a general-purpose output byte, an eight-character ASCII display, a soft-reset trigger, and the control bits of a bit-banged two-wire serial bus. It also has a switch register that is read-only.

Software can fill the display in two ways. It can write a whole 32-bit word, which the block turns into eight uppercase hexadecimal ASCII characters. It can also write single characters through eight per-character registers spaced eight bytes apart. The display characters and LED bits leave the block as parallel outputs for an external renderer. The two-wire bus lines come out as SCL and SDA levels, and the live level of the serial data input can be read back.

Register offsets (low 20 address bits): switch 0x00100, LED bar 0x00200, display word 0x00410, display character k at 0x00418 + 8·k (k = 0..7), soft reset 0x00500, general output 0x00A00, two-wire input 0x00B00, two-wire output-enable 0x00B08, two-wire output 0x00B10, two-wire select 0x00B18.

Top module: `brd_ctrl_regs`

## Requirements
- R1: Decoding uses only address bits [19:0]. An access to 0xFFF00200 reaches the same LED register as an access to 0x00200.
- R2: The switch register always reads 0, meaning every switch is closed. Writes to it change nothing that can be read back.
- R3: A write to the LED bar register stores wdata[7:0] on `led_o`. A read returns that byte zero-extended.
- R4: A write to the display word register sets character i (bits [8i+7:8i] of `disp_o`) to the uppercase ASCII hex digit of nibble wdata[31-4i:28-4i]. Character 0 therefore shows the most significant nibble. Digits 0-9 map to 0x30-0x39 and A-F map to 0x41-0x46.
- R5: A write to offset 0x418 + 8·k stores wdata[7:0] as character k and leaves the other characters unchanged. An offset inside that range that is not a multiple of 8 is not decoded.
- R6: `soft_rst_o` is a single-cycle pulse. It goes high in the cycle after a write to the soft-reset register, and at no other time.
- R7: The general output register keeps wdata[7:0] on `gpout_o`. The two-wire output-enable register keeps wdata[1:0] on `tw_oe_o`. The two-wire select register keeps wdata[0] on `tw_sel_o`. Each one reads back its stored value.
- R8: A write to the two-wire output register sets `tw_scl_o` to wdata[1] and `tw_sda_o` to wdata[0]. A read of that register returns {scl, sda} in bits [1:0].
- R9: A read of the two-wire input register returns bit 1 = the current `tw_scl_o` and bit 0 = the level of `tw_sda_i` in the cycle of the read. All other bits are 0.
- R10: After reset, every display character is ASCII space (0x20), `led_o`, `gpout_o`, `tw_oe_o` and `tw_sel_o` are 0, `tw_scl_o` and `tw_sda_o` are 1, and `soft_rst_o`, `bad_addr_o` and `bus_rdata` are 0.
- R11: A read of an undecoded offset returns 0 and raises `bad_addr_o` for one cycle. A write to an undecoded offset changes no output and does not raise `bad_addr_o`.
- R12: `bus_rdata` and `bad_addr_o` update in the cycle after `bus_rd`. `bus_rdata` holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bad_addr_o | output | 1 | One-cycle flag for a read of an undecoded offset |
| led_o | output | 8 | LED bar bits |
| disp_o | output | 64 | Eight display characters, character k in bits [8k+7:8k] |
| soft_rst_o | output | 1 | Soft-reset request pulse |
| gpout_o | output | 8 | General-purpose output byte |
| tw_oe_o | output | 2 | Two-wire output-enable bits |
| tw_scl_o | output | 1 | Two-wire clock line level |
| tw_sda_o | output | 1 | Two-wire data line level |
| tw_sel_o | output | 1 | Two-wire bus select |
| tw_sda_i | input | 1 | Two-wire serial data input |

## Verification
The hardest case to reach from the ports is the difference between offsets that decode and offsets that only look as if they do. The per-character window sits between decoded registers, so a misaligned address inside it must be rejected without disturbing any character. An address whose upper bits are set must still alias onto a real register. The stimulus sends reads and writes to a misaligned character offset, to a gap offset and to an aliased LED address. It checks the whole display vector and the LED byte after each one, and it checks that the bad-address flag stays silent on writes. The two-wire input read is exercised by changing the serial input between two reads, so that bit 0 has to follow the live pin.

// File: rtl/brd_ctrl_pkg.sv
package brd_ctrl_pkg;

  localparam int OFFS_W = 20;

  localparam logic [OFFS_W-1:0] OFF_SWITCH = 20'h00100;
  localparam logic [OFFS_W-1:0] OFF_LED    = 20'h00200;
  localparam logic [OFFS_W-1:0] OFF_WORD   = 20'h00410;
  localparam logic [OFFS_W-1:0] OFF_CHAR0  = 20'h00418;
  localparam logic [OFFS_W-1:0] OFF_SOFT   = 20'h00500;
  localparam logic [OFFS_W-1:0] OFF_GPOUT  = 20'h00A00;
  localparam logic [OFFS_W-1:0] OFF_TWIN   = 20'h00B00;
  localparam logic [OFFS_W-1:0] OFF_TWOE   = 20'h00B08;
  localparam logic [OFFS_W-1:0] OFF_TWOUT  = 20'h00B10;
  localparam logic [OFFS_W-1:0] OFF_TWSEL  = 20'h00B18;

  localparam int CHAR_STRIDE_LG = 3;
  localparam logic [7:0] CHAR_BLANK = 8'h20;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_SWITCH,
    SEL_LED,
    SEL_WORD,
    SEL_CHAR,
    SEL_SOFT,
    SEL_GPOUT,
    SEL_TWIN,
    SEL_TWOE,
    SEL_TWOUT,
    SEL_TWSEL
  } reg_sel_e;

  // One nibble to its uppercase ASCII hex digit.
  function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    else           return 8'h37 + {4'h0, n};
  endfunction

  // Character idx of a word rendered most significant nibble first.
  function automatic logic [7:0] word_char(input logic [31:0] w, input int idx);
    return nib_to_ascii(w[31-4*idx -: 4]);
  endfunction

endpackage

// File: rtl/brd_ctrl_decode.sv
module brd_ctrl_decode
  import brd_ctrl_pkg::*;
#(
  parameter int DEC_W = 20,
  parameter int NCHAR = 8,
  localparam int IDX_W = $clog2(NCHAR)
) (
  input  logic [DEC_W-1:0] offs,
  output reg_sel_e         sel,
  output logic [IDX_W-1:0] char_idx
);

  localparam logic [DEC_W-1:0] CHAR_LO = DEC_W'(OFF_CHAR0);
  localparam logic [DEC_W-1:0] CHAR_HI = DEC_W'(OFF_CHAR0 + (NCHAR << CHAR_STRIDE_LG));
  localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(OFF_CHAR0 >> CHAR_STRIDE_LG);

  logic in_char_win;

  assign in_char_win = (offs >= CHAR_LO) && (offs < CHAR_HI) &&
                       (offs[CHAR_STRIDE_LG-1:0] == '0);
  assign char_idx    = offs[IDX_W+CHAR_STRIDE_LG-1:CHAR_STRIDE_LG] - BASE_IDX;

  always_comb begin
    sel = SEL_NONE;
    if (in_char_win)                    sel = SEL_CHAR;
    else if (offs == DEC_W'(OFF_SWITCH)) sel = SEL_SWITCH;
    else if (offs == DEC_W'(OFF_LED))    sel = SEL_LED;
    else if (offs == DEC_W'(OFF_WORD))   sel = SEL_WORD;
    else if (offs == DEC_W'(OFF_SOFT))   sel = SEL_SOFT;
    else if (offs == DEC_W'(OFF_GPOUT))  sel = SEL_GPOUT;
    else if (offs == DEC_W'(OFF_TWIN))   sel = SEL_TWIN;
    else if (offs == DEC_W'(OFF_TWOE))   sel = SEL_TWOE;
    else if (offs == DEC_W'(OFF_TWOUT))  sel = SEL_TWOUT;
    else if (offs == DEC_W'(OFF_TWSEL))  sel = SEL_TWSEL;
  end

endmodule

// File: rtl/brd_ctrl_display.sv
module brd_ctrl_display
  import brd_ctrl_pkg::*;
#(
  parameter int NCHAR  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NCHAR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_we,
  input  logic              char_we,
  input  logic [IDX_W-1:0]  char_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [8*NCHAR-1:0] chars
);

  for (genvar i = 0; i < NCHAR; i++) begin : g_char
    logic [7:0] ch_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   ch_q <= CHAR_BLANK;
      else if (word_we)                             ch_q <= word_char(wdata, i);
      else if (char_we && char_idx == IDX_W'(i))    ch_q <= wdata[7:0];
    end
    assign chars[8*i +: 8] = ch_q;
  end

endmodule

// File: rtl/brd_ctrl_twowire.sv
module brd_ctrl_twowire (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oe_we,
  input  logic       out_we,
  input  logic       sel_we,
  input  logic [1:0] wbits,
  input  logic       sda_in,
  output logic [1:0] oe,
  output logic       scl,
  output logic       sda,
  output logic       sel,
  output logic [1:0] in_val
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe  <= 2'b00;
      scl <= 1'b1;
      sda <= 1'b1;
      sel <= 1'b0;
    end else begin
      if (oe_we)  oe  <= wbits;
      if (out_we) begin
        scl <= wbits[1];
        sda <= wbits[0];
      end
      if (sel_we) sel <= wbits[0];
    end
  end

  assign in_val = {scl, sda_in};

endmodule

// File: rtl/brd_ctrl_regs.sv
module brd_ctrl_regs
  import brd_ctrl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEC_W  = 20,
  parameter int NCHAR  = 8,
  parameter int LED_W  = 8,
  parameter int GP_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bad_addr_o,
  output logic [LED_W-1:0]   led_o,
  output logic [8*NCHAR-1:0] disp_o,
  output logic               soft_rst_o,
  output logic [GP_W-1:0]    gpout_o,
  output logic [1:0]         tw_oe_o,
  output logic               tw_scl_o,
  output logic               tw_sda_o,
  output logic               tw_sel_o,
  input  logic               tw_sda_i
);

  localparam int IDX_W = $clog2(NCHAR);

  reg_sel_e         sel;
  logic [IDX_W-1:0] char_idx;
  logic [1:0]       tw_in_val;

  // Named decode events, also watched by the checker.
  logic sel_none, sel_led, sel_soft, sel_word, sel_char, sel_twout;
  assign sel_none  = (sel == SEL_NONE);
  assign sel_led   = (sel == SEL_LED);
  assign sel_soft  = (sel == SEL_SOFT);
  assign sel_word  = (sel == SEL_WORD);
  assign sel_char  = (sel == SEL_CHAR);
  assign sel_twout = (sel == SEL_TWOUT);

  brd_ctrl_decode #(.DEC_W(DEC_W), .NCHAR(NCHAR)) u_dec (
    .offs     (bus_addr[DEC_W-1:0]),
    .sel      (sel),
    .char_idx (char_idx)
  );

  brd_ctrl_display #(.NCHAR(NCHAR), .DATA_W(DATA_W)) u_disp (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_we  (bus_wr && sel_word),
    .char_we  (bus_wr && sel_char),
    .char_idx (char_idx),
    .wdata    (bus_wdata),
    .chars    (disp_o)
  );

  brd_ctrl_twowire u_tw (
    .clk    (clk),
    .rst_n  (rst_n),
    .oe_we  (bus_wr && sel == SEL_TWOE),
    .out_we (bus_wr && sel_twout),
    .sel_we (bus_wr && sel == SEL_TWSEL),
    .wbits  (bus_wdata[1:0]),
    .sda_in (tw_sda_i),
    .oe     (tw_oe_o),
    .scl    (tw_scl_o),
    .sda    (tw_sda_o),
    .sel    (tw_sel_o),
    .in_val (tw_in_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_o      <= '0;
      gpout_o    <= '0;
      soft_rst_o <= 1'b0;
    end else begin
      soft_rst_o <= bus_wr && sel_soft;
      if (bus_wr && sel_led)          led_o   <= bus_wdata[LED_W-1:0];
      if (bus_wr && sel == SEL_GPOUT) gpout_o <= bus_wdata[GP_W-1:0];
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_LED:   rd_mux = DATA_W'(led_o);
      SEL_GPOUT: rd_mux = DATA_W'(gpout_o);
      SEL_TWIN:  rd_mux = DATA_W'(tw_in_val);
      SEL_TWOE:  rd_mux = DATA_W'(tw_oe_o);
      SEL_TWOUT: rd_mux = DATA_W'({tw_scl_o, tw_sda_o});
      SEL_TWSEL: rd_mux = DATA_W'(tw_sel_o);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bad_addr_o <= 1'b0;
    end else begin
      bad_addr_o <= bus_rd && sel_none;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/brd_ctrl_regs_chk.sv
module brd_ctrl_regs_chk #(
  parameter int DATA_W = 32,
  parameter int LED_W  = 8,
  parameter int NCHAR  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               bad_addr_o,
  input logic               soft_rst_o,
  input logic [LED_W-1:0]   led_o,
  input logic [8*NCHAR-1:0] disp_o,
  input logic               tw_sda_o,
  input logic               sel_none,
  input logic               sel_led,
  input logic               sel_soft,
  input logic               sel_word,
  input logic               sel_char,
  input logic               sel_twout
);

  p_soft_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !soft_rst_o);

  p_soft_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> $past(bus_wr && sel_soft));

  p_bad_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_addr_o |-> $past(bus_rd && sel_none));

  p_led_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && sel_led) |=> $stable(led_o));

  p_disp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (sel_word || sel_char)) |=> $stable(disp_o));

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  p_sda_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_twout) |=> (tw_sda_o == $past(bus_wdata[0])));

endmodule

bind brd_ctrl_regs brd_ctrl_regs_chk #(.DATA_W(DATA_W), .LED_W(LED_W), .NCHAR(NCHAR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bad_addr_o (bad_addr_o),
  .soft_rst_o (soft_rst_o),
  .led_o      (led_o),
  .disp_o     (disp_o),
  .tw_sda_o   (tw_sda_o),
  .sel_none   (sel_none),
  .sel_led    (sel_led),
  .sel_soft   (sel_soft),
  .sel_word   (sel_word),
  .sel_char   (sel_char),
  .sel_twout  (sel_twout)
);

// File: tb/brd_ctrl_regs_bench.sv
module brd_ctrl_regs_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bad_addr_o;
  logic [7:0]  led_o;
  logic [63:0] disp_o;
  logic        soft_rst_o;
  logic [7:0]  gpout_o;
  logic [1:0]  tw_oe_o;
  logic        tw_scl_o, tw_sda_o, tw_sel_o;
  logic        tw_sda_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brd_ctrl_regs u_brd_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bad_addr_o(bad_addr_o),
    .led_o(led_o), .disp_o(disp_o), .soft_rst_o(soft_rst_o), .gpout_o(gpout_o),
    .tw_oe_o(tw_oe_o), .tw_scl_o(tw_scl_o), .tw_sda_o(tw_sda_o), .tw_sel_o(tw_sel_o),
    .tw_sda_i(tw_sda_i)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [23:0] tag;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 32'h0000_0200, 32'h1234_56A5, 32'h0, "R3 "},
    '{1'b0, 32'h0000_0200, 32'h0,         32'h0000_00A5, "R3 "},
    '{1'b0, 32'h0000_0100, 32'h0,         32'h0, "R2 "},
    '{1'b1, 32'h0000_0100, 32'hFFFF_FFFF, 32'h0, "R2 "},
    '{1'b0, 32'h0000_0100, 32'h0,         32'h0, "R2 "},
    '{1'b1, 32'h0000_0A00, 32'h0000_ABCD, 32'h0, "R7 "},
    '{1'b0, 32'h0000_0A00, 32'h0,         32'h0000_00CD, "R7 "},
    '{1'b1, 32'h0000_0B08, 32'hFFFF_FFFF, 32'h0, "R7 "},
    '{1'b0, 32'h0000_0B08, 32'h0,         32'h0000_0003, "R7 "},
    '{1'b1, 32'h0000_0B18, 32'h0000_0003, 32'h0, "R7 "},
    '{1'b0, 32'h0000_0B18, 32'h0,         32'h0000_0001, "R7 "},
    '{1'b1, 32'hFFF0_0200, 32'h0000_003C, 32'h0, "R1 "},
    '{1'b0, 32'h0000_0200, 32'h0,         32'h0000_003C, "R1 "},
    '{1'b0, 32'hABC0_0200, 32'h0,         32'h0000_003C, "R1 "}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d, output logic bad);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    bad = bad_addr_o;
  endtask

  function automatic logic [63:0] render(input logic [31:0] w);
    string hexs = "0123456789ABCDEF";
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = hexs[(w >> (28 - 4*k)) & 32'hF];
    return r;
  endfunction

  initial begin
    logic [31:0] rd;
    logic        bad;
    logic [63:0] disp_before;
    logic [63:0] exp_disp;

    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 chars", disp_o, {8{8'h20}});
    chk("R10 outs", {56'h0, led_o}, {56'h0, 8'h00});
    chk("R10 misc", {55'h0, gpout_o, tw_oe_o, tw_scl_o, tw_sda_o, tw_sel_o, soft_rst_o},
        {55'h0, 8'h00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0});
    chk("R10 rd", {31'h0, bus_rdata, bad_addr_o}, 64'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].wr) bus_write(VECS[v].addr, VECS[v].data);
      else begin
        bus_read(VECS[v].addr, rd, bad);
        chk(string'(VECS[v].tag), {32'h0, rd}, {32'h0, VECS[v].exp});
      end
    end
    chk("R3 led pins", {56'h0, led_o}, {56'h0, 8'h3C});
    chk("R7 pins", {46'h0, gpout_o, tw_oe_o, tw_sel_o, 7'h0}, {46'h0, 8'hCD, 2'b11, 1'b1, 7'h0});

    // R4: word rendering
    bus_write(32'h0000_0410, 32'h1F2E_3D4C);
    chk("R4 word", disp_o, render(32'h1F2E_3D4C));
    bus_write(32'h0000_0410, 32'hA0B9_C8FF);
    chk("R4 word2", disp_o, render(32'hA0B9_C8FF));

    // R5: per-character writes
    exp_disp = render(32'hA0B9_C8FF);
    bus_write(32'h0000_0450, 32'h0000_0141);
    exp_disp[63:56] = 8'h41;
    chk("R5 char7", disp_o, exp_disp);
    bus_write(32'h0000_0418, 32'h0000_007A);
    exp_disp[7:0] = 8'h7A;
    chk("R5 char0", disp_o, exp_disp);
    bus_write(32'h0000_0430, 32'h0000_0023);
    exp_disp[31:24] = 8'h23;
    chk("R5 char3", disp_o, exp_disp);

    // R5/R11: misaligned offset inside the window is undecoded
    disp_before = disp_o;
    bus_write(32'h0000_041C, 32'h0000_0055);
    chk("R5 misaligned write", disp_o, disp_before);
    bus_read(32'h0000_041C, rd, bad);
    chk("R11 misaligned read", {31'h0, rd, bad}, {31'h0, 32'h0, 1'b1});

    // R11: gap offset
    bus_read(32'h0000_0300, rd, bad);
    chk("R11 gap read", {31'h0, rd, bad}, {31'h0, 32'h0, 1'b1});
    @(negedge clk);
    chk("R11 bad one cycle", {63'h0, bad_addr_o}, 64'h0);
    bus_write(32'h0000_0300, 32'hFFFF_FFFF);
    chk("R11 gap write", {led_o, gpout_o, 47'h0, bad_addr_o}, {8'h3C, 8'hCD, 47'h0, 1'b0});
    chk("R11 gap write disp", disp_o, disp_before);

    // R6: soft-reset pulse
    bus_write(32'h0000_0500, 32'h0000_0001);
    chk("R6 pulse high", {63'h0, soft_rst_o}, 64'h1);
    @(negedge clk);
    chk("R6 pulse low", {63'h0, soft_rst_o}, 64'h0);
    bus_write(32'h0000_0200, 32'h0000_0011);
    chk("R6 no pulse", {63'h0, soft_rst_o}, 64'h0);

    // R8: two-wire output
    bus_write(32'h0000_0B10, 32'hFFFF_FFF2);
    chk("R8 scl/sda", {62'h0, tw_scl_o, tw_sda_o}, {62'h0, 2'b10});
    bus_read(32'h0000_0B10, rd, bad);
    chk("R8 readback", {32'h0, rd}, 64'h2);
    bus_write(32'h0000_0B10, 32'h0000_0001);
    chk("R8 scl/sda 2", {62'h0, tw_scl_o, tw_sda_o}, {62'h0, 2'b01});

    // R9: two-wire input follows live data line
    tw_sda_i = 1'b1;
    bus_read(32'h0000_0B00, rd, bad);
    chk("R9 in sda=1", {32'h0, rd}, 64'h1);
    tw_sda_i = 1'b0;
    bus_write(32'h0000_0B10, 32'h0000_0003);
    bus_read(32'h0000_0B00, rd, bad);
    chk("R9 in sda=0", {32'h0, rd}, 64'h2);

    // R12: read data holds without a read
    repeat (3) @(negedge clk);
    chk("R12 hold", {32'h0, bus_rdata}, 64'h2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule